// File: doc/BRIEF.md
# Pseudo-SRAM Device Emulator

A clock-sampled, synthesizable stand-in for an asynchronous-SRAM-compatible pseudo-SRAM. It has a 16-bit data bus split into a lower and an upper byte lane. Every rising clock edge samples the control pins: two chip enables, write enable, output enable and one enable per lane. All of these are active low except the second chip enable. A system model or a test environment puts it where a real memory part would sit, so that controller logic can be exercised against it at cycle level.

Writes follow the asynchronous convention. Address, data and lane mask are held while the write is active, and the word is committed when the write phase ends. Reads come out after a fixed number of clocks. The bidirectional data pins are split into an input bus, an output bus and one output enable per lane. The enclosing design joins these into its tri-state pad.

Dropping the second chip enable puts the part in deep power-down, and all stored contents are lost. A lost word reads back as a fixed poison pattern until it is written again, so a controller that forgets to reload the memory is caught at once. The depth is a parameter, so a small array can be used in simulation.

Top module: `psram_emu`

## Requirements
- R1: The device is selected only while `ce1_n`=0 and `ce2`=1. With any other combination, both bits of `dq_oe` are 0.
- R2: A write is active while the device is selected and `we_n`=0, whatever the level of `oe_n`. The word is committed at the first clock edge where the write is no longer active, whether `we_n` rose or the device was deselected by `ce1_n`. The commit uses the address, data and lanes sampled at the last active edge.
- R3: While `we_n`=0, both bits of `dq_oe` are 0.
- R4: A read needs the device selected, `we_n`=1 and `oe_n`=0. The word at the address sampled at a clock edge appears on `dq_o` READ_LAT edges later, and until then the previous word is held. While `oe_n`=1, `dq_oe` is 0.
- R5: `lb_n` (active low) gates bits 7:0 and maps to `dq_oe[0]`. `ub_n` gates bits 15:8 and maps to `dq_oe[1]`. A lane whose enable is 1 is neither written (its stored byte is kept) nor driven.
- R6: With the device selected and both `lb_n` and `ub_n` at 1, both lanes stay undriven.
- R7: `addr[2:0]` selects a word within an 8-word page, and the upper bits select the page. With the read controls held, each change of the low bits returns the newly addressed word after READ_LAT edges.
- R8: Any edge with `ce2`=0 marks every word as lost and discards a write in progress. A lost word reads as POISON (default 16'hDEAD) until it is written. A single-lane write to a lost word leaves the other lane's POISON byte in place.
- R9: After reset, both lanes are undriven and every word reads as POISON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address; bits 2:0 select the word within a page |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high; low means deep power-down |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane drive enable: bit 1 for the upper byte, bit 0 for the lower byte |

## Verification
The assertions check the drive-enable rules on every cycle. They confirm that nothing is driven while the device is deselected, being written, output-disabled, or has a lane turned off. The bench scenarios are what show the data-path behaviour:
- the commit at the end of a write, including a write ended by deselect;
- byte merging into existing or poisoned words;
- the exact read latency and the hold of the previous word;
- the page walk in a scrambled order;
- the loss of data, and of a pending write, on power-down.

// File: rtl/psram_emu.sv
module psram_emu #(
  parameter int          ADDR_W   = 6,
  parameter int          READ_LAT = 2,
  parameter logic [15:0] POISON   = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [1:0]        dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0]       mem [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic              sel, wr_now, rd_now, wr_act, commit;
  logic [ADDR_W-1:0] wa;
  logic [15:0]       wd, base, merged, rd_word;
  logic [1:0]        wm, lanes;
  logic [15:0]       pd [READ_LAT];
  logic [1:0]        pe [READ_LAT];

  assign sel     = !ce1_n && ce2;
  assign wr_now  = sel && !we_n;
  assign rd_now  = sel && we_n && !oe_n;
  assign lanes   = ~{ub_n, lb_n};
  assign commit  = wr_act && !wr_now && ce2;
  assign base    = valid[wa] ? mem[wa] : POISON;
  assign merged  = {wm[1] ? wd[15:8] : base[15:8], wm[0] ? wd[7:0] : base[7:0]};
  assign rd_word = valid[addr] ? mem[addr] : POISON;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act <= 1'b0;
      wa     <= '0;
      wd     <= '0;
      wm     <= '0;
      valid  <= '0;
    end else begin
      wr_act <= wr_now;
      if (wr_now) begin
        wa <= addr;
        wd <= dq_i;
        wm <= lanes;
      end
      if (!ce2) valid <= '0;
      else if (commit) valid[wa] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wa] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < READ_LAT; i++) begin
        pd[i] <= '0;
        pe[i] <= '0;
      end
    end else begin
      pd[0] <= rd_word;
      pe[0] <= rd_now ? lanes : 2'b00;
      for (int i = 1; i < READ_LAT; i++) begin
        pd[i] <= pd[i-1];
        pe[i] <= pe[i-1];
      end
    end
  end

  assign dq_o  = pd[READ_LAT-1];
  assign dq_oe = pe[READ_LAT-1] & (rd_now ? lanes : 2'b00);
endmodule

module psram_emu_props (
  input logic       clk,
  input logic       rst_n,
  input logic       ce1_n,
  input logic       ce2,
  input logic       we_n,
  input logic       oe_n,
  input logic       lb_n,
  input logic       ub_n,
  input logic [1:0] dq_oe
);
  a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n || !ce2) |-> dq_oe == 2'b00);
  a_r3_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe == 2'b00);
  a_r4_oe_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dq_oe == 2'b00);
  a_r5_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    lb_n |-> !dq_oe[0]);
  a_r5_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ub_n |-> !dq_oe[1]);
  a_r6_both_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |-> dq_oe == 2'b00);
endmodule

bind psram_emu psram_emu_props u_props (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n),
  .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .dq_oe(dq_oe)
);

// File: tb/psram_emu_test.sv
`timescale 1ns/1ps
module psram_emu_test;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic ce1_n = 1'b1, ce2 = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0] dq_i = '0, dq_o;
  logic [1:0]  dq_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psram_emu #(.ADDR_W(6), .READ_LAT(LAT), .POISON(16'hDEAD)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
    .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe));

  typedef struct packed {
    logic [5:0]  a;
    logic        lb;
    logic        ub;
    logic [15:0] d;
    logic [1:0]  oe;
  } vec_t;

  // R7 page walk in scrambled order; R5/R6 lane cases
  localparam vec_t TBL [8] = '{
    '{6'd11, 1'b0, 1'b0, 16'hA353, 2'b11},
    '{6'd8,  1'b0, 1'b0, 16'hA050, 2'b11},
    '{6'd15, 1'b0, 1'b0, 16'hA757, 2'b11},
    '{6'd13, 1'b1, 1'b0, 16'hA555, 2'b10},
    '{6'd9,  1'b0, 1'b1, 16'hA151, 2'b01},
    '{6'd14, 1'b1, 1'b1, 16'hA656, 2'b00},
    '{6'd10, 1'b0, 1'b0, 16'hA252, 2'b11},
    '{6'd12, 1'b0, 1'b0, 16'hA454, 2'b11}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic lb, input logic ub,
                    input logic oe, input bit end_by_deselect);
    ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = oe; addr = a; dq_i = d; lb_n = lb; ub_n = ub;
    @(negedge clk);
    chk("R3 no drive during write", {14'd0, dq_oe}, 16'd0);
    if (end_by_deselect) ce1_n = 1'b1;
    else we_n = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [5:0] a, input logic lb, input logic ub);
    ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = a; lb_n = lb; ub_n = ub;
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset lanes off", {14'd0, dq_oe}, 16'd0);
    rd(6'd0, 1'b0, 1'b0);
    chk("R9 reset word poison", dq_o, 16'hDEAD);

    for (int i = 0; i < 8; i++)
      wr(6'(8 + i), 16'hA050 + 16'(i) * 16'h0101, 1'b0, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < 8; i++) begin
      rd(TBL[i].a, TBL[i].lb, TBL[i].ub);
      chk("R7 page word", dq_o & {{8{TBL[i].oe[1]}}, {8{TBL[i].oe[0]}}},
          TBL[i].d & {{8{TBL[i].oe[1]}}, {8{TBL[i].oe[0]}}});
      chk("R5 R6 lane enables", {14'd0, dq_oe}, {14'd0, TBL[i].oe});
    end

    rd(6'd11, 1'b0, 1'b0);
    addr = 6'd8;
    @(negedge clk);
    chk("R4 hold before latency", dq_o, 16'hA353);
    @(negedge clk);
    chk("R4 new word at latency", dq_o, 16'hA050);
    oe_n = 1'b1;
    @(negedge clk);
    chk("R4 oe_n high hiz", {14'd0, dq_oe}, 16'd0);
    oe_n = 1'b0; ce1_n = 1'b1;
    repeat (LAT) @(negedge clk);
    chk("R1 ce1_n high hiz", {14'd0, dq_oe}, 16'd0);
    idle();

    wr(6'd9, 16'hFF77, 1'b0, 1'b1, 1'b1, 1'b0);
    rd(6'd9, 1'b0, 1'b0);
    chk("R5 lower lane only written", dq_o, 16'hA177);

    ce1_n = 1'b0; we_n = 1'b0; addr = 6'd40; dq_i = 16'h4444; lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R1 ce2 low hiz", {14'd0, dq_oe}, 16'd0);
    idle();
    rd(6'd40, 1'b0, 1'b0);
    chk("R8 pending write discarded", dq_o, 16'hDEAD);
    rd(6'd8, 1'b0, 1'b0);
    chk("R8 contents lost", dq_o, 16'hDEAD);

    wr(6'd30, 16'h5A00, 1'b1, 1'b0, 1'b1, 1'b0);
    rd(6'd30, 1'b0, 1'b0);
    chk("R8 partial write keeps poison byte", dq_o, 16'h5AAD);

    wr(6'd20, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(6'd20, 1'b0, 1'b0);
    chk("R2 commit on deselect with oe_n low", dq_o, 16'h1234);
    wr(6'd21, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b0);
    rd(6'd21, 1'b0, 1'b0);
    chk("R2 commit on we_n rise", dq_o, 16'hBEEF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule